// File: doc/BRIEF.md
# Transmit Frame-Sync Source Selector

This block creates the internal transmit frame-sync strobe of a serial port and controls the bidirectional frame-sync pin. It is clocked by the bit clock. Two configuration bits pick the source of the sync. The first is the drive bit. The second is the generator-pick bit, which is only read while the drive bit is set.

With the drive bit clear, the pin is an input. Its value is resynchronised and then conditioned by the polarity bit. With the drive bit set, the pin is an output. It then carries either the pulse from the sample-rate generator or a one-bit-clock pulse made from the copy of the holding register into the shift register. In both cases the pin value is conditioned by the same polarity bit.

The sample-rate generator and the shift register lie outside the block and appear here only as strobes. An interrupt pulse can flag each newly detected frame. All pins are plain control signals, since no data stream passes through the block. The transmitter-enable input holds the sync, the interrupt and the driven pin quiet.

Top module: `txfs_select`

## Requirements
- R1: With cfg_drive = 0, fs_int equals pin_in XOR cfg_invert as sampled three rising edges earlier: two synchroniser stages, then the output register. gen_pulse and copy_strobe have no effect in this mode.
- R2: With cfg_drive = 1 and cfg_use_gen = 1, fs_int equals gen_pulse as sampled on the previous rising edge. copy_strobe and pin_in have no effect.
- R3: With cfg_drive = 1 and cfg_use_gen = 0, a 0-to-1 change of copy_strobe seen at edge e makes fs_int high for exactly one cycle, after edge e+1, even if copy_strobe stays high. gen_pulse and pin_in have no effect.
- R4: pin_oe equals cfg_drive at all times, whatever the state of tx_active.
- R5: When cfg_drive = 1 and tx_active = 1, pin_out equals fs_int XOR cfg_invert in the same cycle. Otherwise pin_out settles to cfg_invert after the next edge.
- R6: With cfg_irq_mode = 2'b10 and tx_active = 1, irq_fs is high for one cycle, in the first cycle in which fs_int is 1 after a cycle in which it was 0. For any other cfg_irq_mode value, irq_fs stays 0.
- R7: While tx_active = 0, fs_int and irq_fs are 0 from the next rising edge on. The synchroniser and the copy edge detector keep running during this time.
- R8: During reset (rst_n = 0, asynchronous, active low), fs_int, irq_fs and pin_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmitter out of reset |
| cfg_drive | input | 1 | 1: internal source, pin driven; 0: pin is the source |
| cfg_use_gen | input | 1 | With cfg_drive = 1: 1 picks the generator, 0 picks the copy event |
| cfg_invert | input | 1 | Polarity of the pin, applied both in and out |
| cfg_irq_mode | input | 2 | Interrupt source; 2'b10 means frame-sync detect |
| gen_pulse | input | 1 | Frame-sync pulse from the sample-rate generator |
| copy_strobe | input | 1 | High when the holding register is copied into the shift register |
| pin_in | input | 1 | Level seen on the frame-sync pin |
| pin_out | output | 1 | Level driven on the frame-sync pin |
| pin_oe | output | 1 | Output enable of the frame-sync pin |
| fs_int | output | 1 | Internal transmit frame sync, active high |
| irq_fs | output | 1 | Frame-sync-detect interrupt pulse |

## Verification
The embedded assertions check four properties on every cycle:
- a copy-made pulse never lasts two cycles;
- a quiet transmitter gives no sync or interrupt and leaves the pin at its idle level;
- the interrupt only marks a rising sync;
- the generator path has a one-cycle delay.

The three-edge latency of the external path, the polarity handling on both directions and the fact that the unselected sources are ignored depend on history across mode changes. These are shown only by the bench scenarios against its reference model. The same holds for the interrupt-mode gating and the reset values.

// File: rtl/txfs_pkg.sv
package txfs_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_GEN  = 2'd1,
    SRC_COPY = 2'd2
  } fs_src_e;

  localparam int unsigned IRQ_MODE_W  = 2;
  localparam logic [IRQ_MODE_W-1:0] IRQ_ON_FS = 2'b10;

  function automatic fs_src_e pick_src(input logic drive, input logic use_gen);
    if (!drive)  return SRC_PIN;
    if (use_gen) return SRC_GEN;
    return SRC_COPY;
  endfunction
endpackage

// File: rtl/txfs_sync.sv
module txfs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txfs_copy_pulse.sv
module txfs_copy_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic pulse
);
  logic strobe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      strobe_d <= strobe;
      pulse    <= strobe & ~strobe_d;
    end
  end

  a_r3_one_bit_wide: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/txfs_out_stage.sv
module txfs_out_stage
  import txfs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_active,
  input  fs_src_e               src,
  input  logic                  cfg_invert,
  input  logic [IRQ_MODE_W-1:0] cfg_irq_mode,
  input  logic                  pin_sync,
  input  logic                  gen_pulse,
  input  logic                  copy_pulse,
  output logic                  fs_int,
  output logic                  pin_out,
  output logic                  irq_fs
);
  logic sel_sync;
  logic drive_pin;

  always_comb begin
    unique case (src)
      SRC_GEN:  sel_sync = gen_pulse;
      SRC_COPY: sel_sync = copy_pulse;
      default:  sel_sync = pin_sync ^ cfg_invert;
    endcase
  end

  assign drive_pin = (src != SRC_PIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_int  <= 1'b0;
      pin_out <= 1'b0;
      irq_fs  <= 1'b0;
    end else begin
      fs_int  <= tx_active & sel_sync;
      pin_out <= (drive_pin & tx_active & sel_sync) ^ cfg_invert;
      irq_fs  <= tx_active & (cfg_irq_mode == IRQ_ON_FS) & sel_sync & ~fs_int;
    end
  end

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> (!fs_int && !irq_fs && (pin_out == $past(cfg_invert))));

  a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fs |-> (fs_int && !$past(fs_int)));

  a_r2_gen_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && src == SRC_GEN) |=> (fs_int == $past(gen_pulse)));
endmodule

// File: rtl/txfs_select.sv
module txfs_select
  import txfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_active,
  input  logic                  cfg_drive,
  input  logic                  cfg_use_gen,
  input  logic                  cfg_invert,
  input  logic [IRQ_MODE_W-1:0] cfg_irq_mode,
  input  logic                  gen_pulse,
  input  logic                  copy_strobe,
  input  logic                  pin_in,
  output logic                  pin_out,
  output logic                  pin_oe,
  output logic                  fs_int,
  output logic                  irq_fs
);
  fs_src_e src;
  logic    pin_sync;
  logic    copy_pulse;

  assign src    = pick_src(cfg_drive, cfg_use_gen);
  assign pin_oe = cfg_drive;

  txfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  txfs_copy_pulse u_copy (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (copy_strobe),
    .pulse  (copy_pulse)
  );

  txfs_out_stage u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_active    (tx_active),
    .src          (src),
    .cfg_invert   (cfg_invert),
    .cfg_irq_mode (cfg_irq_mode),
    .pin_sync     (pin_sync),
    .gen_pulse    (gen_pulse),
    .copy_pulse   (copy_pulse),
    .fs_int       (fs_int),
    .pin_out      (pin_out),
    .irq_fs       (irq_fs)
  );
endmodule

// File: tb/txfs_select_tb_top.sv
module txfs_select_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic cfg_drive = 1'b0;
  logic cfg_use_gen = 1'b0;
  logic cfg_invert = 1'b0;
  logic [1:0] cfg_irq_mode = 2'b00;
  logic gen_pulse = 1'b0;
  logic copy_strobe = 1'b0;
  logic pin_in = 1'b0;
  logic pin_out, pin_oe, fs_int, irq_fs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic m_s1, m_s2, m_cd, m_cq, m_fs, m_pin, m_irq;
  string m_tag;

  always #2ns clk = ~clk;

  txfs_select dut_i (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .cfg_drive(cfg_drive),
    .cfg_use_gen(cfg_use_gen), .cfg_invert(cfg_invert), .cfg_irq_mode(cfg_irq_mode),
    .gen_pulse(gen_pulse), .copy_strobe(copy_strobe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fs_int(fs_int), .irq_fs(irq_fs)
  );

  function automatic logic f_sync(input logic drive, input logic use_gen, input logic inv,
                                  input logic s2, input logic genp, input logic cq);
    if (!drive) return s2 ^ inv;   // R1
    if (use_gen) return genp;      // R2
    return cq;                     // R3
  endfunction

  function automatic string f_tag(input logic act, input logic drive, input logic use_gen);
    if (!act) return "R7";
    if (!drive) return "R1";
    return use_gen ? "R2" : "R3";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cd = 0; m_cq = 0; m_fs = 0; m_pin = 0; m_irq = 0;
      m_tag = "R8";
    end else begin
      logic ns;
      ns = f_sync(cfg_drive, cfg_use_gen, cfg_invert, m_s2, gen_pulse, m_cq);
      m_irq = tx_active && cfg_irq_mode == 2'b10 && ns && !m_fs;
      m_fs  = tx_active && ns;
      m_pin = (cfg_drive && tx_active && ns) ^ cfg_invert;
      m_tag = f_tag(tx_active, cfg_drive, cfg_use_gen);
      m_cq  = copy_strobe && !m_cd;
      m_cd  = copy_strobe;
      m_s2  = m_s1;
      m_s1  = pin_in;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(m_tag, "fs_int", fs_int, m_fs);
    chk("R5", "pin_out", pin_out, m_pin);
    chk("R4", "pin_oe", pin_oe, cfg_drive);
    chk("R6", "irq_fs", irq_fs, m_irq);
  endtask

  task automatic cfg(input logic act, input logic drv, input logic ug,
                     input logic inv, input logic [1:0] im);
    tx_active = act; cfg_drive = drv; cfg_use_gen = ug; cfg_invert = inv; cfg_irq_mode = im;
  endtask

  initial begin
    #400us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cp;
    void'($urandom(32'h1234_5678));
    cfg(1, 1, 1, 1, 2'b10);
    gen_pulse = 1;
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8", "fs_int", fs_int, 1'b0);
    chk("R8", "irq_fs", irq_fs, 1'b0);
    chk("R8", "pin_out", pin_out, 1'b0);
    gen_pulse = 0;
    rst_n = 1;

    // R1: external pin, both polarities, other strobes toggling
    cfg(1, 0, 1, 0, 2'b10);
    for (int i = 0; i < 24; i++) begin
      pin_in = (i % 5) < 2; gen_pulse = i[0]; copy_strobe = i[1];
      if (i == 12) cfg_invert = 1;
      cyc();
    end
    // R1 latency: a single-cycle pin pulse shows three edges later
    pin_in = 0; cfg_invert = 0;
    repeat (4) cyc();
    pin_in = 1; cyc(); pin_in = 0;
    cyc(); chk("R1", "fs_int early", fs_int, 1'b0);
    cyc(); chk("R1", "fs_int at third edge", fs_int, 1'b1);

    // R2: generator path, pin_in ignored
    cfg(1, 1, 1, 0, 2'b10);
    for (int i = 0; i < 20; i++) begin
      gen_pulse = (i % 4) == 0; pin_in = ~pin_in; copy_strobe = i[2];
      if (i == 10) cfg_invert = 1;
      cyc();
    end
    gen_pulse = 0;

    // R3: copy path, strobe held high gives one pulse
    cfg(1, 1, 0, 1, 2'b10);
    copy_strobe = 0; repeat (2) cyc();
    copy_strobe = 1; gen_pulse = 1;
    cyc(); chk("R3", "fs_int before pulse", fs_int, 1'b0);
    cyc(); chk("R3", "fs_int pulse", fs_int, 1'b1);
    cyc(); chk("R3", "fs_int one wide", fs_int, 1'b0);
    repeat (4) cyc();
    chk("R3", "fs_int held strobe", fs_int, 1'b0);
    copy_strobe = 0; gen_pulse = 0; repeat (2) cyc();

    // R6: interrupt gated by mode
    cfg(1, 1, 1, 0, 2'b01);
    for (int i = 0; i < 12; i++) begin gen_pulse = (i % 3) == 0; cyc(); end
    cfg(1, 1, 1, 0, 2'b10);
    gen_pulse = 1; repeat (3) cyc();
    chk("R6", "irq single on long sync", irq_fs, 1'b0);
    gen_pulse = 0; cyc();

    // R7: inactive transmitter
    cfg(0, 1, 1, 1, 2'b10);
    for (int i = 0; i < 10; i++) begin gen_pulse = i[0]; copy_strobe = i[1]; cyc(); end
    chk("R7", "pin idle level", pin_out, 1'b1);
    chk("R4", "oe while inactive", pin_oe, 1'b1);

    // random mix
    cp = 0;
    for (int i = 0; i < 4000; i++) begin
      if ((i % 50) == 0) begin
        cp = $urandom;
        cfg((cp % 8) != 0, cp[4], cp[5], cp[6], cp[8:7]);
      end
      gen_pulse   = ($urandom % 5) == 0;
      copy_strobe = ($urandom % 3) == 0;
      pin_in      = ($urandom % 4) == 0 ? ~pin_in : pin_in;
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule